// File: doc/BRIEF.md
# Dual-Halfword Dot-Product Accumulator

The block keeps a bank of four 64-bit signed accumulators, each held as a high word and a low word. An operation names one accumulator by a 2-bit index and supplies two 32-bit source words. Each word splits into two signed 16-bit halves. The block forms two signed products from those halves and adds them to, or subtracts them from, the named accumulator. The result is written back in the same clock cycle.

A 2-bit mode picks how the halves pair up and how the products are used:

- **Straight pairing:** low half with low half, high half with high half.
- **Crossed pairing:** the low half of the first word with the high half of the second, and the reverse.
- **Crossed fractional (Q15):** crossed pairing with doubled products and a special case for -1 times -1.
- **Mixed:** subtracts the low-lane product and adds the high-lane product.

A per-operation saturation request clamps the result to the signed 32-bit range. Each accumulator has a sticky overflow flag, cleared by a per-flag mask. A host port writes any accumulator directly. A separate read index brings out one accumulator combinationally.

Top module: `dot_acc`

## Requirements
- R1: After reset all four accumulators read zero and all four flags are zero.
- R2: Mode 0 (straight) adds lo(A)*lo(B) + hi(A)*hi(B), as signed 16-bit products, to the selected accumulator. With op_sub_i=1 it subtracts both products instead.
- R3: Mode 1 (crossed) uses the pairs lo(A)*hi(B) and hi(A)*lo(B). op_sub_i selects add or subtract as in R2.
- R4: Mode 2 (crossed fractional) uses the pairings of R3, but each product is doubled before it is accumulated.
- R5: In mode 2, a lane whose two halves both equal 0x8000 contributes 0x7FFFFFFF, and the selected accumulator's flag is set.
- R6: With op_sat_i=1, a result above 0x7FFFFFFF becomes 0x7FFFFFFF and a result below -0x80000000 becomes -0x80000000. Either clamp sets the selected flag. A clamped value is stored sign-extended to 64 bits.
- R7: Mode 3 (mixed) accumulates hi(A)*hi(B) - lo(A)*lo(B). op_sub_i has no effect in this mode.
- R8: A host write loads {wr_hi_i, wr_lo_i} into accumulator wr_sel_i. The new value is visible on the readback port after the next clock edge. Readback shows accumulator rd_sel_i as {rd_hi_o, rd_lo_o} with no added latency.
- R9: When a host write and an operation target the same accumulator in one cycle, the operation's result is stored and the write is dropped.
- R10: Flags are sticky until cleared: flag_clr_i[k]=1 clears flag k, and a flag set in the same cycle as its clear stays set.
- R11: Without saturation the accumulator wraps modulo 2^64.
- R12: An operation or write changes only the accumulator it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Perform an operation this cycle |
| op_mode_i | input | 2 | 0 straight, 1 crossed, 2 crossed fractional, 3 mixed |
| op_sub_i | input | 1 | Subtract products (modes 0 to 2) |
| op_sat_i | input | 1 | Clamp result to signed 32-bit range |
| op_sel_i | input | 2 | Target accumulator of the operation |
| src_a_i | input | 32 | First source word |
| src_b_i | input | 32 | Second source word |
| wr_en_i | input | 1 | Host write enable |
| wr_sel_i | input | 2 | Host write target |
| wr_hi_i | input | 32 | Host write high word |
| wr_lo_i | input | 32 | Host write low word |
| rd_sel_i | input | 2 | Readback index |
| rd_hi_o | output | 32 | Readback high word |
| rd_lo_o | output | 32 | Readback low word |
| flag_clr_i | input | 4 | Per-flag clear mask |
| flags_o | output | 4 | Sticky overflow flags, bit k for accumulator k |

## Verification
The assertions assume that every control input and index is a known value at each rising edge. Properties that relate an update to the readback port only use cycles in which rd_sel_i points at the accumulator just updated, so they make no assumption about how the read index moves. The stimulus drives every input at the falling edge and draws indices from their full 2-bit range. Operands are biased toward 0x8000 halves so that the fractional corner and both clamp directions occur often alongside plain random traffic.

// File: rtl/dot_acc_pkg.sv
package dot_acc_pkg;
  typedef enum logic [1:0] {
    MODE_STRAIGHT   = 2'b00,
    MODE_CROSS      = 2'b01,
    MODE_FRAC_CROSS = 2'b10,
    MODE_MIXED      = 2'b11
  } dot_mode_e;
endpackage

// File: rtl/dot_lane_mul.sv
module dot_lane_mul #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]          x_i,
  input  logic [HALF_W-1:0]          y_i,
  input  logic                       frac_i,
  output logic signed [2*HALF_W-1:0] prod_o,
  output logic                       corner_o
);
  localparam int PW = 2 * HALF_W;
  localparam logic [HALF_W-1:0] NEG_ONE = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic signed [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] xe, ye, raw;

  assign xe  = {{HALF_W{x_i[HALF_W-1]}}, x_i};
  assign ye  = {{HALF_W{y_i[HALF_W-1]}}, y_i};
  assign raw = xe * ye;

  assign corner_o = frac_i && (x_i == NEG_ONE) && (y_i == NEG_ONE);

  always_comb begin
    if (corner_o)    prod_o = POS_MAX;
    else if (frac_i) prod_o = raw <<< 1;
    else             prod_o = raw;
  end
endmodule

// File: rtl/dot_acc_update.sv
module dot_acc_update #(
  parameter int ACC_W  = 64,
  parameter int PROD_W = 32
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic signed [PROD_W-1:0] p0_i,
  input  logic signed [PROD_W-1:0] p1_i,
  input  logic                     neg0_i,
  input  logic                     neg1_i,
  input  logic                     sat_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic                     clamp_o
);
  localparam int EXT = ACC_W - PROD_W;
  localparam logic signed [ACC_W-1:0] MAXV = {{(EXT+1){1'b0}}, {(PROD_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {{(EXT+1){1'b1}}, {(PROD_W-1){1'b0}}};

  logic signed [ACC_W-1:0] e0, e1, t0, t1, sum;
  logic over_hi, over_lo;

  assign e0  = {{EXT{p0_i[PROD_W-1]}}, p0_i};
  assign e1  = {{EXT{p1_i[PROD_W-1]}}, p1_i};
  assign t0  = neg0_i ? -e0 : e0;
  assign t1  = neg1_i ? -e1 : e1;
  assign sum = acc_i + t0 + t1;

  assign over_hi = sat_i && (sum > MAXV);
  assign over_lo = sat_i && (sum < MINV);
  assign clamp_o = over_hi || over_lo;

  always_comb begin
    if (over_hi)      acc_o = MAXV;
    else if (over_lo) acc_o = MINV;
    else              acc_o = sum;
  end
endmodule

// File: rtl/dot_acc.sv
module dot_acc
  import dot_acc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_ACC = 4,
  localparam int IDX_W  = $clog2(NUM_ACC),
  localparam int HALF_W = DATA_W / 2,
  localparam int ACC_W  = 2 * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [1:0]         op_mode_i,
  input  logic               op_sub_i,
  input  logic               op_sat_i,
  input  logic [IDX_W-1:0]   op_sel_i,
  input  logic [DATA_W-1:0]  src_a_i,
  input  logic [DATA_W-1:0]  src_b_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_sel_i,
  input  logic [DATA_W-1:0]  wr_hi_i,
  input  logic [DATA_W-1:0]  wr_lo_i,
  input  logic [IDX_W-1:0]   rd_sel_i,
  output logic [DATA_W-1:0]  rd_hi_o,
  output logic [DATA_W-1:0]  rd_lo_o,
  input  logic [NUM_ACC-1:0] flag_clr_i,
  output logic [NUM_ACC-1:0] flags_o
);
  dot_mode_e mode;
  logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic [HALF_W-1:0] x0, y0, x1, y1;
  logic frac, neg0, neg1;
  logic signed [DATA_W-1:0] p0, p1;
  logic corner0, corner1, clamp, op_flag;
  logic signed [ACC_W-1:0] acc_cur, acc_nxt;
  logic [DATA_W-1:0] hi_q [NUM_ACC];
  logic [DATA_W-1:0] lo_q [NUM_ACC];
  logic [NUM_ACC-1:0] flag_q;

  assign mode = dot_mode_e'(op_mode_i);
  assign {a_hi, a_lo} = src_a_i;
  assign {b_hi, b_lo} = src_b_i;
  assign frac = (mode == MODE_FRAC_CROSS);

  // lane pairing and per-lane sign
  always_comb begin
    x0 = a_lo; x1 = a_hi;
    y0 = b_lo; y1 = b_hi;
    neg0 = op_sub_i; neg1 = op_sub_i;
    case (mode)
      MODE_CROSS, MODE_FRAC_CROSS: begin
        y0 = b_hi; y1 = b_lo;
      end
      MODE_MIXED: begin
        neg0 = 1'b1; neg1 = 1'b0;
      end
      default: ;
    endcase
  end

  dot_lane_mul #(.HALF_W(HALF_W)) u_mul0 (
    .x_i(x0), .y_i(y0), .frac_i(frac), .prod_o(p0), .corner_o(corner0));
  dot_lane_mul #(.HALF_W(HALF_W)) u_mul1 (
    .x_i(x1), .y_i(y1), .frac_i(frac), .prod_o(p1), .corner_o(corner1));

  assign acc_cur = {hi_q[op_sel_i], lo_q[op_sel_i]};

  dot_acc_update #(.ACC_W(ACC_W), .PROD_W(DATA_W)) u_upd (
    .acc_i(acc_cur), .p0_i(p0), .p1_i(p1), .neg0_i(neg0), .neg1_i(neg1),
    .sat_i(op_sat_i), .acc_o(acc_nxt), .clamp_o(clamp));

  assign op_flag = corner0 || corner1 || clamp;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic hit_op, hit_wr, flag_r;
    logic [DATA_W-1:0] hi_r, lo_r;

    assign hit_op = op_valid_i && (op_sel_i == IDX_W'(g));
    assign hit_wr = wr_en_i && (wr_sel_i == IDX_W'(g)) && !hit_op;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_r   <= '0;
        lo_r   <= '0;
        flag_r <= 1'b0;
      end else begin
        if (hit_op) begin
          hi_r <= acc_nxt[ACC_W-1:DATA_W];
          lo_r <= acc_nxt[DATA_W-1:0];
        end else if (hit_wr) begin
          hi_r <= wr_hi_i;
          lo_r <= wr_lo_i;
        end
        flag_r <= (flag_r && !flag_clr_i[g]) || (hit_op && op_flag);
      end
    end

    assign hi_q[g]   = hi_r;
    assign lo_q[g]   = lo_r;
    assign flag_q[g] = flag_r;
  end

  assign rd_hi_o = hi_q[rd_sel_i];
  assign rd_lo_o = lo_q[rd_sel_i];
  assign flags_o = flag_q;
endmodule

// File: rtl/dot_acc_chk.sv
module dot_acc_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_ACC = 4,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_valid_i,
  input logic [1:0]         op_mode_i,
  input logic               op_sub_i,
  input logic               op_sat_i,
  input logic [IDX_W-1:0]   op_sel_i,
  input logic [DATA_W-1:0]  src_a_i,
  input logic [DATA_W-1:0]  src_b_i,
  input logic               wr_en_i,
  input logic [IDX_W-1:0]   wr_sel_i,
  input logic [DATA_W-1:0]  wr_hi_i,
  input logic [DATA_W-1:0]  wr_lo_i,
  input logic [IDX_W-1:0]   rd_sel_i,
  input logic [DATA_W-1:0]  rd_hi_o,
  input logic [DATA_W-1:0]  rd_lo_o,
  input logic [NUM_ACC-1:0] flag_clr_i,
  input logic [NUM_ACC-1:0] flags_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [HALF_W-1:0] NEG_ONE = {1'b1, {(HALF_W-1){1'b0}}};

  // R10: a flag not cleared never drops
  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flags_o) & ~$past(flag_clr_i) & ~flags_o) == '0));

  // R5, R6: flags only rise on an operation
  p_flag_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> ((flags_o & ~$past(flags_o)) == '0));

  // R5: fractional corner on the low lane sets the target flag
  p_corner_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_mode_i == 2'b10 && src_a_i[HALF_W-1:0] == NEG_ONE
     && src_b_i[DATA_W-1:HALF_W] == NEG_ONE) |=> flags_o[$past(op_sel_i)]);

  // R6: saturated result is a sign-extended 32-bit value
  p_sat_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_sat_i) ##1 (rd_sel_i == $past(op_sel_i))
    |-> (rd_hi_o == {DATA_W{rd_lo_o[DATA_W-1]}}));

  // R8, R9: an unopposed host write lands
  p_host_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(op_valid_i && op_sel_i == wr_sel_i)) ##1 (rd_sel_i == $past(wr_sel_i))
    |-> (rd_hi_o == $past(wr_hi_i) && rd_lo_o == $past(wr_lo_i)));

  // R12: nothing changes without an operation or write
  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !wr_en_i) ##1 $stable(rd_sel_i)
    |-> ($stable(rd_hi_o) && $stable(rd_lo_o)));
endmodule

bind dot_acc dot_acc_chk #(.DATA_W(DATA_W), .NUM_ACC(NUM_ACC)) u_chk (.*);

// File: tb/dot_acc_test.sv
module dot_acc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_sub = 1'b0, op_sat = 1'b0, wr_en = 1'b0;
  logic [1:0] op_mode = '0, op_sel = '0, wr_sel = '0, rd_sel = '0;
  logic [31:0] src_a = '0, src_b = '0, wr_hi = '0, wr_lo = '0;
  logic [31:0] rd_hi, rd_lo;
  logic [3:0] flag_clr = '0, flags;

  longint acc_m [4];
  logic [3:0] flags_m;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dot_acc uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_mode_i(op_mode),
    .op_sub_i(op_sub), .op_sat_i(op_sat), .op_sel_i(op_sel), .src_a_i(src_a),
    .src_b_i(src_b), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_hi_i(wr_hi),
    .wr_lo_i(wr_lo), .rd_sel_i(rd_sel), .rd_hi_o(rd_hi), .rd_lo_o(rd_lo),
    .flag_clr_i(flag_clr), .flags_o(flags));

  function automatic longint lane(logic [15:0] x, logic [15:0] y, bit frac, output bit corner);
    longint xi = longint'($signed(x));
    longint yi = longint'($signed(y));
    corner = frac && x == 16'h8000 && y == 16'h8000;
    if (corner) return 64'sd2147483647;
    return frac ? 2 * xi * yi : xi * yi;
  endfunction

  task automatic check_all(string tag, int tgt);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1;
      n_vec++;
      if ({rd_hi, rd_lo} !== acc_m[i]) begin
        n_bad++;
        $display("FAIL %s acc%0d: got %h expected %h", (i == tgt) ? tag : "R12",
                 i, {rd_hi, rd_lo}, acc_m[i]);
      end
    end
    n_vec++;
    if (flags !== flags_m) begin
      n_bad++;
      $display("FAIL %s flags: got %b expected %b", tag, flags, flags_m);
    end
  endtask

  task automatic step(string tag, bit v, logic [1:0] md, bit sb, bit st, logic [1:0] sel,
                      logic [31:0] a, logic [31:0] b, bit we, logic [1:0] ws,
                      logic [63:0] wv, logic [3:0] clr);
    bit c0, c1, fl;
    longint p0, p1, s;
    @(negedge clk);
    op_valid = v; op_mode = md; op_sub = sb; op_sat = st; op_sel = sel;
    src_a = a; src_b = b; wr_en = we; wr_sel = ws;
    wr_hi = wv[63:32]; wr_lo = wv[31:0]; flag_clr = clr;
    flags_m = flags_m & ~clr;
    if (we && !(v && sel == ws)) acc_m[ws] = longint'(wv);
    if (v) begin
      if (md == 2'd0)      begin p0 = lane(a[15:0], b[15:0], 0, c0);  p1 = lane(a[31:16], b[31:16], 0, c1); end
      else if (md == 2'd3) begin p0 = lane(a[15:0], b[15:0], 0, c0);  p1 = lane(a[31:16], b[31:16], 0, c1); end
      else                 begin p0 = lane(a[15:0], b[31:16], md == 2'd2, c0); p1 = lane(a[31:16], b[15:0], md == 2'd2, c1); end
      s = acc_m[sel];
      if (md == 2'd3) s = s - p0 + p1;
      else if (sb)    s = s - p0 - p1;
      else            s = s + p0 + p1;
      fl = c0 || c1;
      if (st && s > 64'sd2147483647)  begin s = 64'sd2147483647; fl = 1'b1; end
      if (st && s < -64'sd2147483648) begin s = -64'sd2147483648; fl = 1'b1; end
      acc_m[sel] = s;
      if (fl) flags_m[sel] = 1'b1;
    end
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0; flag_clr = '0;
    check_all(tag, v ? int'(sel) : int'(ws));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    for (int i = 0; i < 4; i++) acc_m[i] = 0;
    flags_m = '0;
    repeat (3) @(negedge clk);
    check_all("R1", 0);
    rst_n = 1'b1;

    // R2 straight add then subtract: 3*5 + (-2)*7 = 1
    step("R2", 1, 2'd0, 0, 0, 2'd0, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 0, 0);
    step("R2", 1, 2'd0, 1, 0, 2'd0, 32'h7FFF_8000, 32'h7FFF_8000, 0, 0, 0, 0);
    // R3 crossed
    step("R3", 1, 2'd1, 0, 0, 2'd1, 32'h0002_0003, 32'h0005_FFF9, 0, 0, 0, 0);
    step("R3", 1, 2'd1, 1, 0, 2'd1, 32'h1234_8001, 32'hFEDC_7FFF, 0, 0, 0, 0);
    // R4 fractional crossed, no corner
    step("R4", 1, 2'd2, 0, 0, 2'd2, 32'h4000_C000, 32'h4000_2000, 0, 0, 0, 0);
    // R5 corner on low lane and on high lane
    step("R5", 1, 2'd2, 0, 0, 2'd2, 32'h0001_8000, 32'h8000_0001, 0, 0, 0, 0);
    step("R5", 1, 2'd2, 1, 0, 2'd3, 32'h8000_0000, 32'h0000_8000, 0, 0, 0, 0);
    // R10 clear, then set and clear together
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1100);
    step("R10", 1, 2'd2, 0, 0, 2'd2, 32'h0000_8000, 32'h8000_0000, 0, 0, 0, 4'b0100);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1111);
    // R8 host write, R6 clamp up and down
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 64'h0000_0000_7FFF_FFF0, 0);
    step("R6", 1, 2'd2, 0, 1, 2'd3, 32'h4000_4000, 32'h4000_4000, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 64'hFFFF_FFFF_8000_0010, 0);
    step("R6", 1, 2'd0, 1, 1, 2'd1, 32'h0100_0100, 32'h0100_0100, 0, 0, 0, 0);
    step("R6", 1, 2'd0, 0, 1, 2'd0, 32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0);
    // R7 mixed, subtract request ignored
    step("R7", 1, 2'd3, 1, 0, 2'd0, 32'h0007_0003, 32'h0002_0005, 0, 0, 0, 0);
    step("R7", 1, 2'd3, 0, 0, 2'd0, 32'hFFF0_0010, 32'h0010_FFF0, 0, 0, 0, 0);
    // R9 write vs operation on same accumulator, and on different ones
    step("R9", 1, 2'd0, 0, 0, 2'd2, 32'h0001_0001, 32'h0001_0001, 1, 2'd2, 64'h1111_2222_3333_4444, 0);
    step("R9", 1, 2'd0, 0, 0, 2'd1, 32'h0001_0001, 32'h0001_0001, 1, 2'd2, 64'h5555_6666_7777_8888, 0);
    // R11 wrap at the 64-bit limit
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 0);
    step("R11", 1, 2'd0, 0, 0, 2'd0, 32'h0000_0001, 32'h0000_0001, 0, 0, 0, 0);
    step("R11", 1, 2'd0, 1, 0, 2'd0, 32'h0000_0001, 32'h0000_0001, 0, 0, 0, 0);

    // random traffic with a fixed seed
    void'($urandom(32'hC0FFEE));
    for (int k = 0; k < 600; k++) begin
      ra = $urandom; rb = $urandom;
      if ($urandom % 4 == 0) ra[15:0]  = 16'h8000;
      if ($urandom % 4 == 0) ra[31:16] = 16'h8000;
      if ($urandom % 4 == 0) rb[15:0]  = 16'h8000;
      if ($urandom % 4 == 0) rb[31:16] = 16'h8000;
      step("R12", $urandom % 8 != 0, 2'($urandom), 1'($urandom), $urandom % 4 == 0,
           2'($urandom), ra, rb, $urandom % 6 == 0, 2'($urandom),
           {32'($urandom), 32'($urandom)}, ($urandom % 5 == 0) ? 4'($urandom) : 4'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule